// File: doc/BRIEF.md
# Time-Interleaved Parallel Datapath

This block raises the throughput of a slow combinational function by running several identical copies of it side by side. Input samples arrive one per clock. A rotating one-hot phase pointer hands each sample to the next copy in turn. Each copy has its own input register, so every copy sees a new operand only once every `LANES` cycles and has that many cycles to settle. A multiplexer, steered by the same pointer, picks the copy whose operand has been held for a full rotation. It loads that copy's result into a single output register that runs at the full clock rate.

The phases are modelled as clock enables inside one clock domain. Downstream logic sees one result per clock in input order, after a fixed latency. A valid flag marks the point after reset from which the results are real.

Top module: `interleaved_datapath`

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge sets `phase_o` to 1 (bit 0 set), `out_valid` to 0 and `dout` to 0.
- R2: After every rising edge with `rst_n` high, `phase_o` has exactly one bit set, and that bit has moved up one position, wrapping from bit `LANES-1` to bit 0.
- R3: A copy loads `din` only at an edge where its own `phase_o` bit is set, and keeps it unchanged for the rest of the rotation. The copy for bit k therefore takes samples k, k+LANES, k+2*LANES and so on after reset. A change of `din` at any other edge has no effect on that copy.
- R4: Counting the edges with `rst_n` high since reset, `out_valid` is 0 after edges 1 to `LANES` and 1 from edge `LANES+1` on, until the next reset.
- R5: The copy function is y = ((x XOR (x >> 2)) * 5 + 7) mod 2^WIDTH.
- R6: When `out_valid` is 1 after edge e, `dout` equals the function of the `din` captured at edge e-`LANES`. Results leave in input order, one per clock, with no gaps or repeats. Exactly `LANES` samples are in flight at any time.
- R7: A reset in mid-stream discards every sample still in flight. After the reset, the phase and valid timing of R1, R2 and R4 start over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; all state is updated on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | WIDTH | Input sample, one per clock |
| dout | output | WIDTH | Registered result at the full rate |
| out_valid | output | 1 | High when `dout` carries the result of a real sample |
| phase_o | output | LANES | One-hot phase; bit k is the load enable of copy k |

## Verification
A ring that loses or doubles its token shows on `phase_o` at the very next edge. It also sends results out of order within one rotation. A copy that reloads outside its phase is caught because `din` changes every cycle: the result that copy produces `LANES` cycles later is then that of a neighbouring sample, and it fails the scoreboard compare. A fill flag that is wrong moves the rise of `out_valid` away from edge `LANES+1`. The bench sees this on the first rotation after any reset, including a reset applied while samples are still in flight.

// File: rtl/idp_pkg.sv
`timescale 1ns/1ps
// Package idp_pkg
// Holds the constants of the combinational function shared by every copy.
// Assumes nothing beyond WIDTH being larger than MIX_SHIFT.
package idp_pkg;
    localparam int MIX_SHIFT = 2;
    localparam int MIX_MULT  = 5;
    localparam int MIX_ADD   = 7;
endpackage

// File: rtl/idp_phase_ring.sv
`timescale 1ns/1ps
// Module idp_phase_ring
// One-hot ring counter that produces the round-robin load phases.
// Assumes LANES >= 1; with a single lane the phase is held constantly active.
module idp_phase_ring #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [LANES-1:0] phase
);
    localparam logic [LANES-1:0] START = LANES'(1);

    logic [LANES-1:0] ring_q;

    generate
        if (LANES == 1) begin : g_single
            // Single lane: the only copy loads on every edge.
            always_ff @(posedge clk) begin
                ring_q <= START;
            end
        end else begin : g_ring
            // Rotate the token up one lane per clock; reset puts it on lane 0.
            always_ff @(posedge clk) begin
                if (!rst_n) ring_q <= START;
                else        ring_q <= {ring_q[LANES-2:0], ring_q[LANES-1]};
            end
        end
    endgenerate

    assign phase = ring_q;
endmodule

// File: rtl/idp_lane.sv
`timescale 1ns/1ps
// Module idp_lane
// One copy of the datapath: an input register that loads on its own phase,
// followed by the combinational mixing function. The register holds for a full
// rotation, so the function has LANES cycles to settle.
// Assumes load is asserted for at most one cycle in each rotation.
module idp_lane #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] result,
    output logic             filled
);
    localparam logic [WIDTH-1:0] MULT_W = WIDTH'(idp_pkg::MIX_MULT);
    localparam logic [WIDTH-1:0] ADD_W  = WIDTH'(idp_pkg::MIX_ADD);

    logic [WIDTH-1:0] hold_q;
    logic [WIDTH-1:0] mixed;

    // Capture the sample on this lane's phase and mark the lane as holding data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            filled <= 1'b0;
        end else if (load) begin
            hold_q <= din;
            filled <= 1'b1;
        end
    end

    // The slow function: fold the operand onto itself, then scale and offset it.
    always_comb begin
        mixed  = hold_q ^ (hold_q >> idp_pkg::MIX_SHIFT);
        result = mixed * MULT_W + ADD_W;
    end
endmodule

// File: rtl/idp_merge.sv
`timescale 1ns/1ps
// Module idp_merge
// N-to-1 one-hot AND-OR multiplexer feeding the full-rate output register.
// The lane selected is the one about to be reloaded, whose operand has been
// stable for a whole rotation. Assumes sel is one-hot.
module idp_merge #(
    parameter int WIDTH = 16,
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       sel,
    input  logic [LANES*WIDTH-1:0] lane_res,
    input  logic [LANES-1:0]       lane_fill,
    output logic [WIDTH-1:0]       dout,
    output logic                   out_valid
);
    logic [WIDTH-1:0] pick_res;
    logic             pick_fill;

    // OR together every lane's result, masked by its select bit.
    always_comb begin
        pick_res  = '0;
        pick_fill = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            pick_res  = pick_res | (lane_res[k*WIDTH +: WIDTH] & {WIDTH{sel[k]}});
            pick_fill = pick_fill | (lane_fill[k] & sel[k]);
        end
    end

    // Register the chosen result and its fill flag every fast clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout      <= '0;
            out_valid <= 1'b0;
        end else begin
            dout      <= pick_res;
            out_valid <= pick_fill;
        end
    end
endmodule

// File: rtl/interleaved_datapath.sv
`timescale 1ns/1ps
// Module interleaved_datapath
// Top level: the phase ring, LANES copies of the function, and the merge stage.
// Takes one sample per clock and gives one result per clock, LANES edges after
// the sample was captured. Assumes a single clock domain; phases are enables.
module interleaved_datapath #(
    parameter int WIDTH = 16,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             out_valid,
    output logic [LANES-1:0] phase_o
);
    logic [LANES-1:0]       phase;
    logic [LANES*WIDTH-1:0] lane_res_flat;
    logic [LANES-1:0]       lane_fill;

    idp_phase_ring #(.LANES(LANES)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            idp_lane #(.WIDTH(WIDTH)) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .load   (phase[k]),
                .din    (din),
                .result (lane_res_flat[k*WIDTH +: WIDTH]),
                .filled (lane_fill[k])
            );
        end
    endgenerate

    idp_merge #(.WIDTH(WIDTH), .LANES(LANES)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (phase),
        .lane_res  (lane_res_flat),
        .lane_fill (lane_fill),
        .dout      (dout),
        .out_valid (out_valid)
    );

    assign phase_o = phase;
endmodule

// File: rtl/interleaved_datapath_checker.sv
`timescale 1ns/1ps
// Module interleaved_datapath_checker
// Property checks on the phase ring, lane holding and output valid timing.
// Attached to every instance of the top module by the bind below.
module interleaved_datapath_checker #(
    parameter int WIDTH = 16,
    parameter int LANES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES-1:0]       phase,
    input logic                   out_valid,
    input logic [LANES*WIDTH-1:0] lane_res_flat
);
    function automatic logic [LANES-1:0] rot_up(input logic [LANES-1:0] v);
        return (v << 1) | (v >> (LANES - 1));
    endfunction

    // R1: a reset edge leaves the token on lane 0 and the output invalid.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (phase == LANES'(1)) && !out_valid);

    // R2: exactly one phase is active at any time.
    p_phase_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);

    // R2: the token advances one lane per clock.
    p_phase_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> phase == rot_up($past(phase)));

    // R4: once valid, the output stays valid until reset.
    p_valid_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

    // R4: the first valid result is the one from lane 0.
    p_first_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> phase == rot_up(LANES'(1)));

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_hold
            // R3: a lane's result cannot change on an edge outside its phase.
            p_lane_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !phase[k] |=> $stable(lane_res_flat[k*WIDTH +: WIDTH]));
        end
    endgenerate
endmodule

bind interleaved_datapath interleaved_datapath_checker #(
    .WIDTH (WIDTH),
    .LANES (LANES)
) u_idp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .phase         (phase_o),
    .out_valid     (out_valid),
    .lane_res_flat (lane_res_flat)
);

// File: tb/interleaved_datapath_bench.sv
`timescale 1ns/1ps
// Bench: a driver pushes expected results into a queue while it applies samples;
// a monitor pops them and compares them with the output once out_valid is high.
module interleaved_datapath_bench;
    localparam int WIDTH = 16;
    localparam int LANES = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic             out_valid;
    logic [LANES-1:0] phase_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [WIDTH-1:0] exp_q[$];
    string rst_tag = "R1";

    interleaved_datapath #(.WIDTH(WIDTH), .LANES(LANES)) u_interleaved_datapath (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .dout      (dout),
        .out_valid (out_valid),
        .phase_o   (phase_o)
    );

    always #2 clk = ~clk;

    // R5: reference function, written from the requirement
    function automatic logic [WIDTH-1:0] ref_f(input logic [WIDTH-1:0] x);
        logic [WIDTH-1:0] t;
        t = x ^ (x >> 2);
        return t * WIDTH'(5) + WIDTH'(7);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic drive(input logic [WIDTH-1:0] v);
        din = v;
        exp_q.push_back(ref_f(v));
        @(negedge clk);
    endtask

    task automatic do_reset(input int cycles);
        rst_n = 1'b0;
        exp_q.delete();
        repeat (cycles) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: checks the ports shortly after each rising edge.
    initial begin
        int live = 0;
        logic [LANES-1:0] exp_phase = LANES'(1);
        forever begin
            logic rst_seen;
            @(posedge clk);
            rst_seen = rst_n;
            #1;
            if (!rst_seen) begin
                live = 0;
                exp_phase = LANES'(1);
                check(phase_o == LANES'(1), rst_tag, "phase in reset", 64'(phase_o), 64'(1));
                check(out_valid == 1'b0, rst_tag, "valid in reset", 64'(out_valid), 64'(0));
                check(dout == '0, rst_tag, "dout in reset", 64'(dout), 64'(0));
            end else begin
                live++;
                exp_phase = (exp_phase << 1) | (exp_phase >> (LANES - 1));
                check(phase_o == exp_phase, "R2", "phase rotation", 64'(phase_o), 64'(exp_phase));
                check(out_valid == (live >= LANES + 1), "R4 R7", "valid timing",
                      64'(out_valid), 64'(live >= LANES + 1));
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6", "result with empty scoreboard", 64'(dout), 64'(0));
                    end else begin
                        logic [WIDTH-1:0] e;
                        e = exp_q.pop_front();
                        check(dout == e, "R3 R5 R6", "result", 64'(dout), 64'(e));
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Driver: stimulus sequence.
    initial begin
        rst_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Ramp: distinct value each cycle, so a lane reloading off-phase is caught (R3)
        for (int i = 0; i < 40; i++) drive(WIDTH'(i));
        // Random stream
        for (int i = 0; i < 150; i++) drive(WIDTH'($urandom()));
        // R7: reset with samples in flight, then a short burst and another reset
        rst_tag = "R7";
        do_reset(3);
        for (int i = 0; i < 3; i++) drive(WIDTH'(16'hA5A0 + i));
        do_reset(2);
        // Extremes alternating every cycle
        for (int i = 0; i < 20; i++) drive((i % 2 == 0) ? '0 : '1);
        // Constant input
        for (int i = 0; i < 30; i++) drive(WIDTH'(16'h1234));
        // Walking one across the word
        for (int i = 0; i < WIDTH; i++) drive(WIDTH'(1) << i);
        // R6: exactly LANES samples remain in flight
        check(exp_q.size() == LANES, "R6", "samples in flight",
              64'(exp_q.size()), 64'(LANES));
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule